// File: doc/BRIEF.md
# Up/Down Timer with Compare and Capture Channels

This block is a binary counter that steps up or down by one on every cycle where the count enable is high. Two compare/capture channels, A and B, sit beside it. Each channel holds one register. In compare mode, the channel raises a match pulse when the counter equals that register. In capture mode, the channel records the counter value when its trigger input rises.

A clear-enable control bit changes how the counter reacts to events on channel A:
- With clear-enable low, the counter behaves as a free-running wrap-around counter.
- With clear-enable high, an A compare match or an A capture restarts the counter from zero.
- With clear-enable high, a count below zero reloads the counter from register A instead of the all-ones value.

Channel B never changes the counter. Software programs the mode bits and the two channel registers over a small register bus. The counter itself can only be read.

Top module: `updn_cc_timer`

## Requirements
- R1: After reset the counter, both channel registers and all mode bits are zero, and every event pulse is low.
- R2: While the initialize bit (control bit 0) is 1, the counter is 0 on the following cycle, and it stays 0 whatever the other inputs are.
- R3: On a clock edge with count enable high, the counter adds one when the direction input is 0 and subtracts one when it is 1. With count enable low the counter does not move, unless an A capture with clear-enable applies (see R9).
- R4: Counting up from the all-ones value gives 0 under either clear-enable setting, and the overflow output pulses high for that one cycle.
- R5: Counting down from 0 gives the all-ones value when clear-enable (control bit 1) is 0, and the value of register A when it is 1. The underflow output pulses high for that one cycle. Overflow and underflow never pulse together.
- R6: In compare mode, if the counter equals register A on a counting edge, the A-match output pulses on the next cycle. With clear-enable 1 the counter becomes 0 instead of stepping.
- R7: In compare mode, if the counter equals register B on a counting edge, the B-match output pulses on the next cycle. The counter steps normally under both clear-enable settings.
- R8: With capture mode set for channel A (control bit 2) or channel B (control bit 3), a rising edge on that channel's trigger copies the present counter value into the channel register. A channel in capture mode gives no match pulses.
- R9: An A capture with clear-enable 1 forces the counter to 0, whether or not count enable is high. A B capture never changes the counter.
- R10: Bus address 0 selects the control bits, address 1 register A, address 2 register B and address 3 the counter. A write to address 3 has no effect.
- R11: When several rules apply on the same edge, the winner follows this order, highest first: initialize, then A-capture clear, then overflow/underflow, then A-match clear, then a plain step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 2 | Write register select |
| bus_wdata | input | CNT_W | Write data |
| bus_rd_addr | input | 2 | Read register select |
| bus_rdata | output | CNT_W | Read data for the selected register (combinational) |
| cnt_en | input | 1 | Count enable, one step per high cycle |
| cnt_down | input | 1 | Direction: 0 counts up, 1 counts down |
| cap_trig_a | input | 1 | Channel A capture trigger (synchronous, rising edge) |
| cap_trig_b | input | 1 | Channel B capture trigger (synchronous, rising edge) |
| match_a | output | 1 | One-cycle pulse after an A compare match |
| match_b | output | 1 | One-cycle pulse after a B compare match |
| ovf | output | 1 | One-cycle pulse after an overflow wrap |
| unf | output | 1 | One-cycle pulse after an underflow reload |

## Verification
The assertions watch several rules on every cycle:
- the counter is zero after initialize;
- the counter holds when idle;
- the counter is zero after an overflow or an A match under clear-enable;
- underflow lands on all-ones without clear-enable;
- overflow and underflow never pulse together.

Only the bench scenarios can show the rest: the underflow reload from register A, the values captured into A and B, B events leaving the counter alone, and the ignored counter write. The bench shows the priority order by sweeping a narrow counter through every wrap and by driving long random mixes of enables, directions, triggers and writes against an arithmetic model.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

   typedef enum logic [1:0] {
      SEL_CTL = 2'd0,
      SEL_CCA = 2'd1,
      SEL_CCB = 2'd2,
      SEL_CNT = 2'd3
   } reg_sel_e;

   localparam int CTL_BITS = 4;

   typedef struct packed {
      logic capb;   // bit 3
      logic capa;   // bit 2
      logic clr;    // bit 1
      logic init;   // bit 0
   } ctl_t;

endpackage

// File: rtl/tmr_ctl.sv
`timescale 1ns/1ps
module tmr_ctl
   import tmr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   output ctl_t         ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_en && (reg_sel_e'(wr_addr) == SEL_CTL)) begin
         ctl <= ctl_t'(wr_data[CTL_BITS-1:0]);
      end
   end

endmodule

// File: rtl/tmr_cc_chan.sv
`timescale 1ns/1ps
module tmr_cc_chan #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_mode,
   input  logic         trig,
   input  logic         wr_hit,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] cnt,
   input  logic         cnt_en,
   input  logic         init,
   output logic [W-1:0] cc_val,
   output logic         cap_evt,
   output logic         match
);

   logic trig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
      end else begin
         trig_q <= trig;
      end
   end

   assign cap_evt = cap_mode & trig & ~trig_q;
   assign match   = cnt_en & ~init & ~cap_mode & (cnt == cc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc_val <= '0;
      end else if (cap_evt) begin
         cc_val <= cnt;
      end else if (wr_hit) begin
         cc_val <= wr_data;
      end
   end

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         clr,
   input  logic         cnt_en,
   input  logic         cnt_down,
   input  logic         cap_a_evt,
   input  logic         match_a_in,
   input  logic         match_b_in,
   input  logic [W-1:0] cca,
   output logic [W-1:0] cnt,
   output logic         match_a,
   output logic         match_b,
   output logic         ovf,
   output logic         unf
);

   localparam logic [W-1:0] ALL_ONES = '1;
   localparam logic [W-1:0] ONE      = W'(1);

   logic [W-1:0] cnt_nxt;
   logic         ovf_nxt, unf_nxt, cap_clr;

   assign cap_clr = clr & cap_a_evt;

   always_comb begin
      cnt_nxt = cnt;
      ovf_nxt = 1'b0;
      unf_nxt = 1'b0;
      if (init) begin
         cnt_nxt = '0;
      end else if (cap_clr) begin
         cnt_nxt = '0;
      end else if (cnt_en) begin
         if (!cnt_down && (cnt == ALL_ONES)) begin
            cnt_nxt = '0;
            ovf_nxt = 1'b1;
         end else if (cnt_down && (cnt == '0)) begin
            cnt_nxt = clr ? cca : ALL_ONES;
            unf_nxt = 1'b1;
         end else if (match_a_in && clr) begin
            cnt_nxt = '0;
         end else if (cnt_down) begin
            cnt_nxt = cnt - ONE;
         end else begin
            cnt_nxt = cnt + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ovf     <= 1'b0;
         unf     <= 1'b0;
         match_a <= 1'b0;
         match_b <= 1'b0;
      end else begin
         cnt     <= cnt_nxt;
         ovf     <= ovf_nxt;
         unf     <= unf_nxt;
         match_a <= match_a_in;
         match_b <= match_b_in;
      end
   end

endmodule

// File: rtl/updn_cc_timer.sv
`timescale 1ns/1ps
module updn_cc_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr_en,
   input  logic [1:0]       bus_wr_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   input  logic [1:0]       bus_rd_addr,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             cnt_en,
   input  logic             cnt_down,
   input  logic             cap_trig_a,
   input  logic             cap_trig_b,
   output logic             match_a,
   output logic             match_b,
   output logic             ovf,
   output logic             unf
);

   localparam int N_CH = 2;

   generate
      if (CNT_W < CTL_BITS) begin : g_bad_width
         $error("updn_cc_timer: CNT_W must be at least %0d", CTL_BITS);
      end
   endgenerate

   ctl_t             ctl_q;
   logic             ctl_init, ctl_clr;
   logic [CNT_W-1:0] cnt_q;
   logic [N_CH-1:0]  ch_mode, ch_trig, ch_wr, ch_cap, ch_match;
   logic [CNT_W-1:0] ch_val [N_CH];

   assign ctl_init = ctl_q.init;
   assign ctl_clr  = ctl_q.clr;

   tmr_ctl #(.W(CNT_W)) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr_en),
      .wr_addr (bus_wr_addr),
      .wr_data (bus_wdata),
      .ctl     (ctl_q)
   );

   assign ch_mode = {ctl_q.capb, ctl_q.capa};
   assign ch_trig = {cap_trig_b, cap_trig_a};
   assign ch_wr   = {bus_wr_en && (reg_sel_e'(bus_wr_addr) == SEL_CCB),
                     bus_wr_en && (reg_sel_e'(bus_wr_addr) == SEL_CCA)};

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         tmr_cc_chan #(.W(CNT_W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_mode (ch_mode[c]),
            .trig     (ch_trig[c]),
            .wr_hit   (ch_wr[c]),
            .wr_data  (bus_wdata),
            .cnt      (cnt_q),
            .cnt_en   (cnt_en),
            .init     (ctl_init),
            .cc_val   (ch_val[c]),
            .cap_evt  (ch_cap[c]),
            .match    (ch_match[c])
         );
      end
   endgenerate

   tmr_counter #(.W(CNT_W)) cnt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .init       (ctl_init),
      .clr        (ctl_clr),
      .cnt_en     (cnt_en),
      .cnt_down   (cnt_down),
      .cap_a_evt  (ch_cap[0]),
      .match_a_in (ch_match[0]),
      .match_b_in (ch_match[1]),
      .cca        (ch_val[0]),
      .cnt        (cnt_q),
      .match_a    (match_a),
      .match_b    (match_b),
      .ovf        (ovf),
      .unf        (unf)
   );

   always_comb begin
      bus_rdata = '0;
      case (reg_sel_e'(bus_rd_addr))
         SEL_CTL: bus_rdata[CTL_BITS-1:0] = ctl_q;
         SEL_CCA: bus_rdata = ch_val[0];
         SEL_CCB: bus_rdata = ch_val[1];
         default: bus_rdata = cnt_q;
      endcase
   end

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cnt_en,
   input logic         init_q,
   input logic         clr_q,
   input logic [W-1:0] cnt,
   input logic         ovf,
   input logic         unf,
   input logic         match_a
);

   AST_INIT_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> (cnt == '0)); // R2

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !init_q && !clr_q) |=> $stable(cnt)); // R3

   AST_OVF_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (cnt == '0)); // R4

   AST_UNF_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (unf && !$past(clr_q)) |-> (cnt == '1)); // R5

   AST_OVF_UNF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ovf, unf})); // R5

   AST_MATCH_A_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a && $past(clr_q)) |-> (cnt == '0)); // R6

endmodule

bind updn_cc_timer tmr_chk #(.W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt_en  (cnt_en),
   .init_q  (ctl_init),
   .clr_q   (ctl_clr),
   .cnt     (cnt_q),
   .ovf     (ovf),
   .unf     (unf),
   .match_a (match_a)
);

// File: tb/updn_cc_timer_tb_top.sv
`timescale 1ns/1ps
module updn_cc_timer_tb_top;

   localparam int W   = 4;
   localparam int MAX = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr_en = 1'b0;
   logic [1:0]   bus_wr_addr = 2'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [1:0]   bus_rd_addr = 2'd3;
   logic [W-1:0] bus_rdata;
   logic         cnt_en = 1'b0, cnt_down = 1'b0;
   logic         cap_trig_a = 1'b0, cap_trig_b = 1'b0;
   logic         match_a, match_b, ovf, unf;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // bench model state
   logic [W-1:0] m_cnt = '0, m_a = '0, m_b = '0;
   logic [3:0]   m_ctl = '0;
   logic         m_pa = 1'b0, m_pb = 1'b0;

   always #2.5 clk = ~clk;

   updn_cc_timer #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wdata(bus_wdata),
      .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
      .cnt_en(cnt_en), .cnt_down(cnt_down),
      .cap_trig_a(cap_trig_a), .cap_trig_b(cap_trig_b),
      .match_a(match_a), .match_b(match_b), .ovf(ovf), .unf(unf)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one clock edge; expected values worked out from the requirements
   task automatic step(input string tag);
      logic [W-1:0] e_cnt, n_a, n_b;
      logic [3:0]   n_ctl;
      logic ra, rb, e_ma, e_mb, e_ov, e_un;
      ra   = m_ctl[2] & cap_trig_a & ~m_pa;
      rb   = m_ctl[3] & cap_trig_b & ~m_pb;
      e_ma = cnt_en & ~m_ctl[0] & ~m_ctl[2] & (m_cnt == m_a);
      e_mb = cnt_en & ~m_ctl[0] & ~m_ctl[3] & (m_cnt == m_b);
      e_ov = 1'b0; e_un = 1'b0; e_cnt = m_cnt;
      if (m_ctl[0]) e_cnt = '0;                       // R11 initialize first
      else if (ra && m_ctl[1]) e_cnt = '0;            // R9
      else if (cnt_en) begin
         if (!cnt_down && int'(m_cnt) == MAX) begin e_cnt = '0; e_ov = 1'b1; end
         else if (cnt_down && m_cnt == '0) begin
            e_cnt = m_ctl[1] ? m_a : W'(MAX); e_un = 1'b1;
         end
         else if (e_ma && m_ctl[1]) e_cnt = '0;
         else e_cnt = W'(cnt_down ? int'(m_cnt) - 1 : int'(m_cnt) + 1);
      end
      n_ctl = (bus_wr_en && bus_wr_addr == 2'd0) ? bus_wdata[3:0] : m_ctl;
      n_a = ra ? m_cnt : ((bus_wr_en && bus_wr_addr == 2'd1) ? bus_wdata : m_a);
      n_b = rb ? m_cnt : ((bus_wr_en && bus_wr_addr == 2'd2) ? bus_wdata : m_b);
      m_pa = cap_trig_a; m_pb = cap_trig_b;
      @(posedge clk); #1;
      m_cnt = e_cnt; m_ctl = n_ctl; m_a = n_a; m_b = n_b;
      vectors++;
      cmp(tag, "counter", int'(bus_rdata), int'(e_cnt));
      cmp(tag, "match_a", int'(match_a), int'(e_ma));
      cmp(tag, "match_b", int'(match_b), int'(e_mb));
      cmp(tag, "ovf", int'(ovf), int'(e_ov));
      cmp(tag, "unf", int'(unf), int'(e_un));
   endtask

   task automatic wr(input int addr, input int data, input string tag);
      bus_wr_en = 1'b1; bus_wr_addr = 2'(addr); bus_wdata = W'(data);
      step(tag);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int addr, input int exp, input string tag);
      bus_rd_addr = 2'(addr); #1;
      vectors++;
      cmp(tag, "read", int'(bus_rdata), exp);
      bus_rd_addr = 2'd3; #1;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic pulse_trig(input bit chan_b, input string tag);
      if (chan_b) cap_trig_b = 1'b1; else cap_trig_a = 1'b1;
      step(tag);
      cap_trig_a = 1'b0; cap_trig_b = 1'b0;
      run(2, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      vectors++;
      cmp("R1", "counter", int'(bus_rdata), 0);
      cmp("R1", "pulses", int'({match_a, match_b, ovf, unf}), 0);
      rd_chk(0, 0, "R1");
      rd_chk(1, 0, "R1");
      rd_chk(2, 0, "R1");

      // R2 initialize holds zero while counting is enabled
      wr(1, 5, "R10"); wr(2, 9, "R10");
      cnt_en = 1'b1; run(4, "R3");
      wr(0, 1, "R2");
      run(5, "R2");
      wr(0, 0, "R2");

      // R3 R4 R6 R7: upward sweep through every value and the wrap
      run(2 * (MAX + 1) + 3, "R4");
      cnt_en = 1'b0; run(4, "R3"); cnt_en = 1'b1;
      // R5 downward sweep with all-ones reload
      cnt_down = 1'b1; run(2 * (MAX + 1) + 3, "R5");

      // clear-enable: A match clears, underflow reloads A
      wr(0, 2, "R6");
      cnt_down = 1'b0; run(MAX + 4, "R6");
      wr(1, 6, "R5");
      cnt_down = 1'b1; run(MAX + 6, "R5");
      wr(1, 0, "R11");                  // A=0: underflow reload vs match clear
      run(6, "R11");
      cnt_down = 1'b0; run(MAX + 3, "R11");
      wr(1, 5, "R5");

      // R8 R9 capture in both channels with clear-enable
      wr(0, 2 | 4 | 8, "R8");
      run(3, "R8");
      pulse_trig(1'b1, "R9");
      rd_chk(2, int'(m_b), "R8");
      run(4, "R8");
      pulse_trig(1'b0, "R9");
      rd_chk(1, int'(m_a), "R8");
      cnt_en = 1'b0; run(3, "R8");
      pulse_trig(1'b0, "R9");           // capture clear while idle
      cap_trig_a = 1'b1; run(3, "R8");  // held level: one capture only
      cap_trig_a = 1'b0; cnt_en = 1'b1;
      wr(0, 8, "R8");                   // capture without clear-enable
      run(5, "R8");
      pulse_trig(1'b1, "R8");
      rd_chk(2, int'(m_b), "R8");
      wr(0, 4, "R8");
      pulse_trig(1'b0, "R8");
      rd_chk(1, int'(m_a), "R8");

      // R10 counter is read-only; control bits read back
      wr(3, 7, "R10");
      rd_chk(0, 4, "R10");

      // R11 random mix against the model
      for (int i = 0; i < 4000; i++) begin
         cnt_en     = ($urandom % 4) != 0;
         cnt_down   = $urandom % 2;
         cap_trig_a = $urandom % 2;
         cap_trig_b = $urandom % 2;
         bus_wr_en  = ($urandom % 8) == 0;
         bus_wr_addr = 2'($urandom % 4);
         bus_wdata  = W'($urandom);
         if (bus_wr_addr == 2'd0 && ($urandom % 4) != 0) bus_wdata[0] = 1'b0;
         step("R11");
      end
      bus_wr_en = 1'b0;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #900000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule